// File: doc/BRIEF.md
# Master-Slave Multi-Channel PWM Timer

This block is a small group of down-counting timer channels that work together to make several pulse-width-modulated outputs sharing one period. Channel 0 is the period master. It counts down from its data value and reloads whenever it reaches zero, so a data value of N gives a period of N+1 count ticks. Every master reload is a period event. The event produces a one-clock `period_irq` pulse and retriggers each slave channel.

Each slave is a one-shot down counter. On a period event it copies its own data register into its counter. From the next count tick its output goes active, and it drops when that counter reaches zero. The slave then rests until the next period event, so its data value is the active width in count ticks. Software starts and stops channels with self-clearing trigger inputs, and it can read each channel's enable flag and live count. For each slave, software can also take the pin away from the timer and drive a level of its own. The prescaler that makes the count clock is not part of the block: a count-enable input marks the ticks.

Top module: `mspwm_group`

## Requirements
- R1: While the master is enabled, its first count tick after a start loads its data value D0 into its counter. Each later tick decrements the counter, and a tick that finds the counter at zero reloads it from D0. Period events are therefore D0+1 ticks apart, and the master count is visible in bits [15:0] of `count_val`.
- R2: `period_irq` is high for exactly the clock that follows a tick in which the master loaded or reloaded. It is never high without such a tick.
- R3: On a period event, an enabled slave s loads its data value Ds into its counter (bits [16(s+1)+15 : 16(s+1)] of `count_val`). With the count enable held high, its timer level rises one clock after `period_irq` is seen high and stays high for Ds ticks. It falls on the tick that finds the counter at zero, and the counter then rests at zero.
- R4: A slave data value of 0 gives an output that never goes active. A slave data value at least the master period keeps the output continuously active.
- R5: A one-clock pulse on bit i of `start_trig` sets enable flag i (bit 0 is the master, bit s+1 is slave s) from the next clock. When start and stop are pulsed for the same channel, stop wins.
- R6: A pulse on bit i of `stop_trig` clears enable flag i. A stopped channel keeps its count value, and its output keeps its present level, even while ticks continue.
- R7: Data written while running does not change the counter in flight. It takes effect only at the next load caused by a period event.
- R8: When `out_en[s]` is 0, `pwm_out[s]` follows `out_lvl[s]`. When `out_en[s]` is 1, it shows the timer level.
- R9: While `cnt_en` is low, no count value changes and no period event occurs.
- R10: Synchronous active-low reset clears all counters, data registers, enable flags and timer levels, and keeps `period_irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Count tick enable (one clock per count tick) |
| start_trig | input | NUM_SLV+1 | Self-clearing start pulses, bit 0 master |
| stop_trig | input | NUM_SLV+1 | Self-clearing stop pulses, bit 0 master |
| data_we | input | NUM_SLV+1 | Data register write strobes, one per channel |
| data_wdata | input | CNT_W | Write data for the data registers |
| out_en | input | NUM_SLV | Per-slave pin source: 1 timer level, 0 software level |
| out_lvl | input | NUM_SLV | Software-written pin level per slave |
| ch_en | output | NUM_SLV+1 | Enable status flags |
| count_val | output | (NUM_SLV+1)*CNT_W | Live counts, channel i at bits [CNT_W*i +: CNT_W] |
| period_irq | output | 1 | One-clock period event pulse |
| pwm_out | output | NUM_SLV | Slave output pins |

## Verification
A trigger pulse or data write presented before an edge shows in `ch_en` or in the data register from that edge on. A master load happens on the first tick after the start edge, and `period_irq` rises on the following edge. A slave level rises on the tick after that load, so with continuous ticks it appears one clock after `period_irq`. The output mux is combinational, so `pwm_out` reflects `out_en` and `out_lvl` in the same clock. Inputs change 5 ns after a rising edge, and all outputs are sampled at the falling edge. There, a behavioural reference model advanced on each rising edge is compared against every output. Directed checks count periods and widths in whole clocks between `period_irq` pulses.

// File: rtl/mspwm_pkg.sv
// Package: shared types of the master-slave PWM timer group.
// Assumes nothing beyond IEEE 1800-2017 synthesis subset.
package mspwm_pkg;
    // Slave one-shot state: resting or counting its active width.
    typedef enum logic {
        SLV_REST = 1'b0,
        SLV_RUN  = 1'b1
    } slv_state_e;
endpackage

// File: rtl/mspwm_enable_ctl.sv
// Module: enable flag register for all channels.
// Turns one-clock start/stop pulses into held enable flags; stop has
// priority. Also flags an accepted master start so the master reloads.
// Assumes triggers are single-clock pulses from the register layer.
module mspwm_enable_ctl #(
    parameter int NUM_CH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] start_trig,
    input  logic [NUM_CH-1:0] stop_trig,
    output logic [NUM_CH-1:0] en,
    output logic              mst_restart
);
    logic [NUM_CH-1:0] en_q;

    // Hold enable flags; stop clears, start sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            en_q <= (en_q | start_trig) & ~stop_trig;
        end
    end

    assign en          = en_q;
    assign mst_restart = start_trig[0] & ~stop_trig[0];
endmodule

// File: rtl/mspwm_master_ch.sv
// Module: period master channel.
// Down counter that loads its data value on the first tick after a start
// and reloads on every tick that finds zero; each load is a period event.
// Assumes tick already combines the count enable with the channel enable.
module mspwm_master_ch #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic             we,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt,
    output logic             evt
);
    logic [CNT_W-1:0] data_q;
    logic [CNT_W-1:0] cnt_q;
    logic             first_q;
    logic             load;

    assign load = first_q || (cnt_q == '0);
    assign evt  = tick && load;

    // Data register, counter and first-load flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            cnt_q   <= '0;
            first_q <= 1'b0;
        end else begin
            if (we) begin
                data_q <= wdata;
            end
            if (tick) begin
                if (load) begin
                    cnt_q   <= data_q;
                    first_q <= 1'b0;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
            if (restart) begin
                first_q <= 1'b1;
            end
        end
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/mspwm_slave_ch.sv
// Module: one-shot PWM slave channel.
// Loads its data value on a master period event, goes active on the next
// tick, counts down and goes inactive on the tick that finds zero.
// Assumes mst_evt is valid only in a master tick cycle.
module mspwm_slave_ch
    import mspwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             mst_evt,
    input  logic             we,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt,
    output logic             lvl
);
    logic [CNT_W-1:0] data_q;
    logic [CNT_W-1:0] cnt_q;
    slv_state_e       st_q;
    logic             lvl_q;

    // Data register, one-shot counter and timer level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            cnt_q  <= '0;
            st_q   <= SLV_REST;
            lvl_q  <= 1'b0;
        end else begin
            if (we) begin
                data_q <= wdata;
            end
            if (tick) begin
                if (mst_evt) begin
                    cnt_q <= data_q;
                    st_q  <= SLV_RUN;
                end else if (st_q == SLV_RUN) begin
                    if (cnt_q == '0) begin
                        lvl_q <= 1'b0;
                        st_q  <= SLV_REST;
                    end else begin
                        lvl_q <= 1'b1;
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
            end
        end
    end

    assign cnt = cnt_q;
    assign lvl = lvl_q;
endmodule

// File: rtl/mspwm_group.sv
// Module: master-slave PWM timer group (top).
// One period master plus NUM_SLV one-shot slaves sharing its period event;
// per-slave pin mux between timer level and a software level.
// Assumes cnt_en is a one-clock tick from an external prescaler.
module mspwm_group #(
    parameter int CNT_W   = 16,
    parameter int NUM_SLV = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cnt_en,
    input  logic [NUM_SLV:0]              start_trig,
    input  logic [NUM_SLV:0]              stop_trig,
    input  logic [NUM_SLV:0]              data_we,
    input  logic [CNT_W-1:0]              data_wdata,
    input  logic [NUM_SLV-1:0]            out_en,
    input  logic [NUM_SLV-1:0]            out_lvl,
    output logic [NUM_SLV:0]              ch_en,
    output logic [(NUM_SLV+1)*CNT_W-1:0]  count_val,
    output logic                          period_irq,
    output logic [NUM_SLV-1:0]            pwm_out
);
    localparam int NUM_CH = NUM_SLV + 1;

    logic [NUM_CH-1:0] en;
    logic              mst_restart;
    logic              mst_evt;
    logic [CNT_W-1:0]  mst_cnt;
    logic [NUM_SLV-1:0] slv_lvl;
    logic              irq_q;

    mspwm_enable_ctl #(.NUM_CH(NUM_CH)) u_en (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_trig (start_trig),
        .stop_trig  (stop_trig),
        .en         (en),
        .mst_restart(mst_restart)
    );

    mspwm_master_ch #(.CNT_W(CNT_W)) u_mst (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (cnt_en & en[0]),
        .restart(mst_restart),
        .we     (data_we[0]),
        .wdata  (data_wdata),
        .cnt    (mst_cnt),
        .evt    (mst_evt)
    );

    assign count_val[CNT_W-1:0] = mst_cnt;

    for (genvar s = 0; s < NUM_SLV; s++) begin : g_slv
        logic [CNT_W-1:0] s_cnt;

        mspwm_slave_ch #(.CNT_W(CNT_W)) u_slv (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (cnt_en & en[s+1]),
            .mst_evt(mst_evt),
            .we     (data_we[s+1]),
            .wdata  (data_wdata),
            .cnt    (s_cnt),
            .lvl    (slv_lvl[s])
        );

        assign count_val[(s+1)*CNT_W +: CNT_W] = s_cnt;
        assign pwm_out[s] = out_en[s] ? slv_lvl[s] : out_lvl[s];
    end

    // Register the period event into a one-clock interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= mst_evt;
        end
    end

    assign period_irq = irq_q;
    assign ch_en      = en;
endmodule

// File: rtl/mspwm_group_chk.sv
// Module: property checker for mspwm_group, bound to every instance.
// Observes ports only; assumes the same parameters as the bound instance.
module mspwm_group_chk #(
    parameter int CNT_W   = 16,
    parameter int NUM_SLV = 2
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          cnt_en,
    input logic [NUM_SLV:0]              start_trig,
    input logic [NUM_SLV:0]              stop_trig,
    input logic [NUM_SLV:0]              data_we,
    input logic [CNT_W-1:0]              data_wdata,
    input logic [NUM_SLV-1:0]            out_en,
    input logic [NUM_SLV-1:0]            out_lvl,
    input logic [NUM_SLV:0]              ch_en,
    input logic [(NUM_SLV+1)*CNT_W-1:0]  count_val,
    input logic                          period_irq,
    input logic [NUM_SLV-1:0]            pwm_out
);
    logic [NUM_SLV:0] go;
    assign go = start_trig & ~stop_trig;

    // R2: an interrupt pulse needs a master tick in the clock before
    a_r2_irq_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        period_irq |-> $past(cnt_en && ch_en[0]));

    // R5: accepted start pulses raise their enable flags
    a_r5_start_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (go != '0) |=> ((ch_en & $past(go)) == $past(go)));

    // R6: stop pulses clear their enable flags
    a_r6_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_trig != '0) |=> ((ch_en & $past(stop_trig)) == '0));

    // R6: a stopped master holds its count
    a_r6_master_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_en[0] |=> $stable(count_val[CNT_W-1:0]));

    // R9: no count moves without a tick
    a_r9_no_tick_no_move: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> $stable(count_val));

    // R10: reset keeps the interrupt low
    a_r10_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !period_irq);

    // Inputs observed for completeness of the bound view.
    logic unused_ok;
    assign unused_ok = ^{data_we, data_wdata, out_en, out_lvl, pwm_out};
endmodule

bind mspwm_group mspwm_group_chk #(.CNT_W(CNT_W), .NUM_SLV(NUM_SLV)) chk_i (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .start_trig(start_trig),
    .stop_trig(stop_trig), .data_we(data_we), .data_wdata(data_wdata),
    .out_en(out_en), .out_lvl(out_lvl), .ch_en(ch_en), .count_val(count_val),
    .period_irq(period_irq), .pwm_out(pwm_out)
);

// File: tb/mspwm_group_tb.sv
// Bench for mspwm_group: behavioural model compared each falling edge,
// plus directed checks of periods, widths, hold and override behaviour.
module mspwm_group_tb_top;
    localparam int CW = 16;
    localparam int NS = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cnt_en = 1'b0;
    logic [NS:0]       start_trig = '0;
    logic [NS:0]       stop_trig = '0;
    logic [NS:0]       data_we = '0;
    logic [CW-1:0]     data_wdata = '0;
    logic [NS-1:0]     out_en = '1;
    logic [NS-1:0]     out_lvl = '0;
    logic [NS:0]       ch_en;
    logic [(NS+1)*CW-1:0] count_val;
    logic              period_irq;
    logic [NS-1:0]     pwm_out;

    always #10 clk = ~clk;   // 50 MHz

    mspwm_group #(.CNT_W(CW), .NUM_SLV(NS)) dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .start_trig(start_trig),
        .stop_trig(stop_trig), .data_we(data_we), .data_wdata(data_wdata),
        .out_en(out_en), .out_lvl(out_lvl), .ch_en(ch_en),
        .count_val(count_val), .period_irq(period_irq), .pwm_out(pwm_out)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit cmp_on = 1'b0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [CW-1:0] m_data, m_cnt;
    logic          m_first;
    logic [NS:0]   m_en;
    logic [CW-1:0] s_data [NS];
    logic [CW-1:0] s_cnt  [NS];
    logic          s_run  [NS];
    logic          s_lvl  [NS];
    logic          m_irq;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_data = '0; m_cnt = '0; m_first = 1'b0; m_en = '0; m_irq = 1'b0;
            for (int s = 0; s < NS; s++) begin
                s_data[s] = '0; s_cnt[s] = '0; s_run[s] = 1'b0; s_lvl[s] = 1'b0;
            end
        end else begin
            bit ev;
            ev = 1'b0;
            if (m_en[0] && cnt_en) begin
                if (m_first || m_cnt == 0) begin
                    m_cnt = m_data; ev = 1'b1; m_first = 1'b0;
                end else begin
                    m_cnt = m_cnt - 1;
                end
            end
            for (int s = 0; s < NS; s++) begin
                if (m_en[s+1] && cnt_en) begin
                    if (ev) begin
                        s_cnt[s] = s_data[s]; s_run[s] = 1'b1;
                    end else if (s_run[s]) begin
                        if (s_cnt[s] == 0) begin
                            s_lvl[s] = 1'b0; s_run[s] = 1'b0;
                        end else begin
                            s_lvl[s] = 1'b1; s_cnt[s] = s_cnt[s] - 1;
                        end
                    end
                end
            end
            m_irq = ev;
            if (data_we[0]) m_data = data_wdata;
            for (int s = 0; s < NS; s++) if (data_we[s+1]) s_data[s] = data_wdata;
            for (int i = 0; i <= NS; i++) begin
                if (stop_trig[i]) m_en[i] = 1'b0;
                else if (start_trig[i]) begin
                    m_en[i] = 1'b1;
                    if (i == 0) m_first = 1'b1;
                end
            end
        end
    end

    // Compare every output against the model on each falling edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R5 ch_en", 64'(ch_en), 64'(m_en));
            chk("R1 master count", 64'(count_val[CW-1:0]), 64'(m_cnt));
            chk("R2 period_irq", 64'(period_irq), 64'(m_irq));
            for (int s = 0; s < NS; s++) begin
                chk("R3 slave count", 64'(count_val[(s+1)*CW +: CW]), 64'(s_cnt[s]));
                chk("R3/R8 pwm_out", 64'(pwm_out[s]),
                    64'(out_en[s] ? s_lvl[s] : out_lvl[s]));
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog expired at cycle %0d expected under 20000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #5;
        end
    endtask

    task automatic wr(input int ch, input logic [CW-1:0] v);
        data_we = '0;
        data_we[ch] = 1'b1;
        data_wdata = v;
        step(1);
        data_we = '0;
    endtask

    task automatic wait_irq();
        int lim = 0;
        do begin
            @(negedge clk);
            lim++;
        end while (!period_irq && lim < 200);
    endtask

    initial begin
        int h0, h1, gap, last;
        logic [(NS+1)*CW-1:0] cv;
        logic [NS-1:0] pw;
        logic [15:0] lf;

        // Reset (R10)
        step(3);
        @(negedge clk);
        chk("R10 ch_en after reset", 64'(ch_en), 64'd0);
        chk("R10 count_val after reset", 64'(count_val), 64'd0);
        chk("R10 irq during reset", 64'(period_irq), 64'd0);
        chk("R10 pwm after reset", 64'(pwm_out), 64'd0);
        step(1);
        rst_n = 1'b1;
        cmp_on = 1'b1;

        // Master 9 (period 10), slave0 width 3, slave1 width 0
        wr(0, 16'd9);
        wr(1, 16'd3);
        wr(2, 16'd0);
        cnt_en = 1'b1;
        start_trig = '1;
        step(1);
        start_trig = '0;
        @(negedge clk);
        chk("R5 all enabled after start", 64'(ch_en), 64'h7);

        wait_irq();
        chk("R3 pwm0 low in irq clock", 64'(pwm_out[0]), 64'd0);
        h0 = 0; h1 = 0; gap = 0;
        for (int i = 1; i <= 10; i++) begin
            @(negedge clk);
            if (i == 1) chk("R3 pwm0 rises one clock after irq", 64'(pwm_out[0]), 64'd1);
            if (pwm_out[0]) h0++;
            if (pwm_out[1]) h1++;
            if (period_irq && gap == 0) gap = i;
        end
        chk("R1 period of D0+1", 64'(gap), 64'd10);
        chk("R3 width of 3", 64'(h0), 64'd3);
        chk("R4 width 0 never active", 64'(h1), 64'd0);

        // R7: rewrite data mid-period; effect only after next reload
        last = cyc;
        step(1);
        wr(0, 16'd4);
        wr(2, 16'd20);
        wait_irq();
        chk("R7 period unchanged in flight", 64'(cyc - last), 64'd10);
        last = cyc;
        wait_irq();
        chk("R7 new period after reload", 64'(cyc - last), 64'd5);
        h1 = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (pwm_out[1]) h1++;
        end
        chk("R4 width beyond period stays active", 64'(h1), 64'd12);

        // R8: software level override
        step(1);
        out_en = 2'b01;
        out_lvl = 2'b10;
        @(negedge clk);
        chk("R8 override high", 64'(pwm_out[1]), 64'd1);
        step(1);
        out_lvl = 2'b00;
        @(negedge clk);
        chk("R8 override low", 64'(pwm_out[1]), 64'd0);
        step(1);
        out_en = 2'b11;

        // R6: stop holds counts and levels while ticks continue
        stop_trig = '1;
        step(1);
        stop_trig = '0;
        @(negedge clk);
        chk("R6 flags cleared", 64'(ch_en), 64'd0);
        cv = count_val;
        pw = pwm_out;
        step(8);
        @(negedge clk);
        chk("R6 counts held", 64'(count_val), 64'(cv));
        chk("R6 levels held", 64'(pwm_out), 64'(pw));
        chk("R6 active slave not reset", 64'(pwm_out[1]), 64'd1);

        // R5: stop wins over start
        start_trig = '1;
        stop_trig = '1;
        step(1);
        start_trig = '0;
        stop_trig = '0;
        @(negedge clk);
        chk("R5 stop has priority", 64'(ch_en), 64'd0);

        // R9: no ticks, nothing moves
        start_trig = '1;
        step(1);
        start_trig = '0;
        step(4);
        cnt_en = 1'b0;
        step(1);
        @(negedge clk);
        cv = count_val;
        h0 = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (period_irq) h0++;
        end
        chk("R9 counts frozen without ticks", 64'(count_val), 64'(cv));
        chk("R9 no irq without ticks", 64'(h0), 64'd0);

        // Mixed run with irregular ticks and data changes (model compare)
        lf = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            cnt_en = lf[0] | lf[3];
            data_we = '0;
            if (lf[7:5] == 3'd0) begin
                data_we[lf[9] ? 1 : (lf[8] ? 2 : 0)] = 1'b1;
                data_wdata = 16'(lf[15:12] % 12);
            end
            out_en = (lf[11:10] == 2'b00) ? 2'b01 : 2'b11;
            out_lvl = lf[2:1];
            step(1);
        end
        data_we = '0;
        step(2);

        cmp_on = 1'b0;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule